// File: doc/BRIEF.md
# Free-Running Timer with Capture and Compare

This block is a 16-bit up-counter that runs continuously. Its count clock comes from one of three fixed divisions of the system clock, or from rising edges on an external clock pin. One capture register records the counter value when the capture pin shows the chosen edge. Two compare channels, A and B, watch the counter. When a channel matches, it drives a programmed level onto its output pin. Channel A can also send the counter back to zero.

Four sticky flags record capture, match A, match B and counter wrap. Software can clear a flag but can never set one. Each flag has an interrupt request line, gated by an enable input. Software reaches every register over a plain write port and a separate combinational read port. A standby-entry strobe returns the status register to zero.

Top module: `frt_timer`

## Requirements
- R1: After reset, the counter, the capture register, the control register (address 4) and the status register (address 5) read 0. Both compare registers (addresses 1 and 2) read 0xFFFF. Both compare pins and all interrupt lines are low.
- R2: The control register holds the clock select in bits 1:0: 00 divides by 4, 01 by 8, 10 by 32. A counter write restarts the division phase. So k clock edges after a counter write of value V, the counter reads V + floor(k/N).
- R3: Clock select 11 counts rising edges of the external clock. The counter advances on the third edge after the pin rises. Falling edges do not count. The divided clock has no effect in this mode.
- R4: The register map is: 0 counter (read/write), 1 compare A, 2 compare B, 3 capture (read only), 4 control, 5 status. A write to the counter loads it and wins over counting.
- R5: A compare match occurs on the count tick that leaves a counter value equal to that channel's compare register. It sets the channel's flag in the same edge: bit 5 of the status register for A, bit 6 for B. When status bit 0 is 0, the counter keeps counting past the match.
- R6: When status bit 0 (clear on match A) is 1, a match on A loads the counter with 0 instead of the next value.
- R7: On a match, each channel's output latch takes that channel's level bit (status bit 2 for A, bit 3 for B) and holds it until the next match. The pin shows the latch only while the channel's enable bit is 1 (control bit 2 for A, bit 3 for B); otherwise the pin is 0.
- R8: Status bit 1 selects the capture edge (1 rising, 0 falling). The third clock edge after the capture pin changes loads the capture register with the counter value from just before that edge and sets status bit 7. The other edge does nothing.
- R9: A count tick at 0xFFFF wraps the counter to 0 and sets status bit 4.
- R10: A write to the status register stores bits 3:0. Any flag (bits 7:4) written 0 is cleared; a flag written 1 keeps its value.
- R11: A flag set event on the same edge as a clearing write leaves the flag set.
- R12: irq_o bit 3 carries capture, bit 2 match B, bit 1 match A and bit 0 overflow. Each bit equals its flag AND-ed with the same bit of irq_mask_i.
- R13: A high sleep_entry_i at a clock edge clears the whole status register, flags included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_entry_i | input | 1 | Standby-entry strobe; clears the status register |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Read data, combinational from rd_addr_i |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| cap_i | input | 1 | Capture trigger pin, asynchronous |
| cmp_a_o | output | 1 | Compare channel A pin |
| cmp_b_o | output | 1 | Compare channel B pin |
| irq_mask_i | input | 4 | Per-flag interrupt enables |
| irq_o | output | 4 | Interrupt requests |

## Verification
Register writes take effect at the write edge, so read-back is checked one half-cycle later. A divided count is due N edges after the counter write that restarted the division. External counts and captures land on the third edge after the pin moves, because of the two synchroniser stages and the edge register. Match and wrap effects (flags, pins, counter clear) appear on the same edge as the tick that causes them, and interrupt lines follow flags and mask with no delay. The driver counts edges from each write or pin change to the cycle in which the result is due. It places expected items in the scoreboard only for that cycle, and the monitor compares them at the following falling edge. Each timed result is also checked one cycle early to show it has not arrived yet.

// File: rtl/frt_pkg.sv
// Package: shared types and constants for the free-running timer.
// Assumes a 3-bit register address space and four status flags.
package frt_pkg;

    localparam int ADDR_W = 3;
    localparam int N_FLAG = 4;

    // Count source selection carried in control bits 1:0.
    typedef enum logic [1:0] {
        CKS_DIV4  = 2'b00,
        CKS_DIV8  = 2'b01,
        CKS_DIV32 = 2'b10,
        CKS_EXT   = 2'b11
    } cks_e;

    // log2 of the fixed division ratios; the prescaler width follows the largest.
    localparam int LOG_DIV4  = 2;
    localparam int LOG_DIV8  = 3;
    localparam int LOG_DIV32 = 5;
    localparam int DIV_W     = LOG_DIV32;

    // Register addresses.
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMPA = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPB = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAP  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

    // Flag positions inside the flag nibble (status bits 7:4).
    localparam int FL_OVF  = 0;
    localparam int FL_CMPA = 1;
    localparam int FL_CMPB = 2;
    localparam int FL_CAP  = 3;

endpackage

// File: rtl/frt_sync_edge.sv
// Module: brings an asynchronous pin into the clock domain through a
// chain of STAGES flops and gives a one-cycle pulse on the chosen edge.
// Assumes STAGES >= 2; the pin is sampled with no glitch filtering.
module frt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic edge_o
);

    logic [STAGES:0] chain_q;
    logic            rise;
    logic            fall;

    // Shift the pin through the synchroniser and keep one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], pin_i};
        end
    end

    // Compare the newest synchronised sample with the one before it.
    always_comb begin
        rise   = chain_q[STAGES-1] & ~chain_q[STAGES];
        fall   = ~chain_q[STAGES-1] & chain_q[STAGES];
        edge_o = rise_sel_i ? rise : fall;
    end

endmodule

// File: rtl/frt_tick_gen.sv
// Module: makes the single-cycle count-enable tick from either a
// free-running divider or the synchronised external clock edge.
// Assumes restart_i is pulsed whenever the counter is loaded.
module frt_tick_gen
    import frt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cks_e cks_i,
    input  logic restart_i,
    input  logic ext_rise_i,
    output logic tick_o
);

    logic [DIV_W-1:0] div_q;

    // Divider runs freely and returns to zero on a counter load.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // A ratio ticks when the low bits of the divider are all ones.
    always_comb begin
        unique case (cks_i)
            CKS_DIV4:  tick_o = &div_q[LOG_DIV4-1:0];
            CKS_DIV8:  tick_o = &div_q[LOG_DIV8-1:0];
            CKS_DIV32: tick_o = &div_q[LOG_DIV32-1:0];
            default:   tick_o = ext_rise_i;
        endcase
    end

endmodule

// File: rtl/frt_cmp_chan.sv
// Module: one output compare channel. Detects a match on the count
// tick, latches the programmed level, and drives the pin when enabled.
// Assumes tick_i is high for one cycle per count step.
module frt_cmp_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             level_i,
    input  logic             oe_i,
    output logic             match_o,
    output logic             pin_o
);

    logic pin_q;

    // Match is qualified by the tick so it fires once per count value.
    always_comb begin
        match_o = tick_i && (cnt_i == cmp_i);
    end

    // Output latch takes the programmed level at each match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (match_o) begin
            pin_q <= level_i;
        end
    end

    // Pin is gated by the channel enable.
    always_comb begin
        pin_o = oe_i & pin_q;
    end

endmodule

// File: rtl/frt_timer.sv
// Module: free-running timer top. Holds the counter, compare, capture,
// control and status registers, the flags and the interrupt gating.
// Assumes one write per cycle and a combinational read port.
module frt_timer
    import frt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_entry_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic [2:0]        rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o,
    input  logic              ext_clk_i,
    input  logic              cap_i,
    output logic              cmp_a_o,
    output logic              cmp_b_o,
    input  logic [3:0]        irq_mask_i,
    output logic [3:0]        irq_o
);

    localparam int N_CMP   = 2;
    localparam int STAT_LO = 4;
    localparam int CTRL_W  = 4;

    // Status low nibble bit positions.
    localparam int S_CCLRA = 0;
    localparam int S_IEDG  = 1;
    localparam int S_LVL0  = 2;
    // Control bit positions.
    localparam int C_OE0   = 2;

    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cap_q;
    logic [CNT_W-1:0]   cmp_q [N_CMP];
    logic [CTRL_W-1:0]  ctrl_q;
    logic [STAT_LO-1:0] stat_lo_q;
    logic [N_FLAG-1:0]  flag_q;
    logic [N_FLAG-1:0]  set_evt;
    logic [N_CMP-1:0]   match;
    logic [N_CMP-1:0]   pin;
    logic               wr_cnt;
    logic               wr_ctrl;
    logic               wr_stat;
    logic               tick;
    logic               ext_rise;
    logic               cap_evt;
    logic               ovf_evt;
    cks_e               cks;

    // Decode the write strobe per register.
    always_comb begin
        wr_cnt  = wr_en_i && (wr_addr_i == A_CNT);
        wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
        wr_stat = wr_en_i && (wr_addr_i == A_STAT);
        cks     = cks_e'(ctrl_q[1:0]);
    end

    frt_sync_edge #(.STAGES(SYNC_STAGES)) i_ext_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (ext_clk_i),
        .rise_sel_i (1'b1),
        .edge_o     (ext_rise)
    );

    frt_sync_edge #(.STAGES(SYNC_STAGES)) i_cap_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (cap_i),
        .rise_sel_i (stat_lo_q[S_IEDG]),
        .edge_o     (cap_evt)
    );

    frt_tick_gen i_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .cks_i      (cks),
        .restart_i  (wr_cnt),
        .ext_rise_i (ext_rise),
        .tick_o     (tick)
    );

    // One compare register and channel per output pin.
    for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
        // Compare register write, reset to all ones.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_q[c] <= '1;
            end else if (wr_en_i && (wr_addr_i == ADDR_W'(A_CMPA + c))) begin
                cmp_q[c] <= wr_data_i;
            end
        end

        frt_cmp_chan #(.CNT_W(CNT_W)) i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .cnt_i   (cnt_q),
            .cmp_i   (cmp_q[c]),
            .level_i (stat_lo_q[S_LVL0 + c]),
            .oe_i    (ctrl_q[C_OE0 + c]),
            .match_o (match[c]),
            .pin_o   (pin[c])
        );
    end

    // Counter: bus load first, then clear on match A, else increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wr_data_i;
        end else if (tick) begin
            cnt_q <= (match[0] && stat_lo_q[S_CCLRA]) ? '0 : cnt_q + 1'b1;
        end
    end

    // Capture register snapshots the counter on the selected edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (cap_evt) begin
            cap_q <= cnt_q;
        end
    end

    // Control register: output enables and clock select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wr_data_i[CTRL_W-1:0];
        end
    end

    // Status low nibble: writable bits, cleared by standby entry.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep_entry_i) begin
            stat_lo_q <= '0;
        end else if (wr_stat) begin
            stat_lo_q <= wr_data_i[STAT_LO-1:0];
        end
    end

    // Collect the hardware events that set each flag.
    always_comb begin
        ovf_evt          = tick && (&cnt_q) && !wr_cnt;
        set_evt          = '0;
        set_evt[FL_OVF]  = ovf_evt;
        set_evt[FL_CMPA] = match[0];
        set_evt[FL_CMPB] = match[1];
        set_evt[FL_CAP]  = cap_evt;
    end

    // Flags: standby clears, events set, a written zero clears.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep_entry_i) begin
            flag_q <= '0;
        end else begin
            for (int f = 0; f < N_FLAG; f++) begin
                if (set_evt[f]) begin
                    flag_q[f] <= 1'b1;
                end else if (wr_stat && !wr_data_i[STAT_LO + f]) begin
                    flag_q[f] <= 1'b0;
                end
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        unique case (rd_addr_i)
            A_CNT:   rd_data_o = cnt_q;
            A_CMPA:  rd_data_o = cmp_q[0];
            A_CMPB:  rd_data_o = cmp_q[1];
            A_CAP:   rd_data_o = cap_q;
            A_CTRL:  rd_data_o = CNT_W'(ctrl_q);
            A_STAT:  rd_data_o = CNT_W'({flag_q, stat_lo_q});
            default: rd_data_o = '0;
        endcase
    end

    // Pins and interrupt requests.
    always_comb begin
        cmp_a_o = pin[0];
        cmp_b_o = pin[1];
        irq_o   = flag_q & irq_mask_i;
    end

endmodule

// File: rtl/frt_timer_chk.sv
// Checker: temporal properties of the free-running timer, bound to
// every frt_timer instance.
module frt_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_i,
    input logic             tick_i,
    input logic             wr_cnt_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic             match_a_i,
    input logic             cclra_i,
    input logic [3:0]       flag_i,
    input logic [3:0]       set_evt_i,
    input logic [3:0]       stat_lo_i,
    input logic [3:0]       irq_i,
    input logic [3:0]       irq_mask_i
);

    // Without a load or a tick the counter holds (R2).
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt_i && !tick_i) |=> $stable(cnt_i));

    // Clear on match A sends the counter to zero (R6).
    assert_clear_on_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && match_a_i && cclra_i && !wr_cnt_i) |=> (cnt_i == '0));

    // Wrap from all ones raises the overflow flag (R9).
    assert_wrap_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (&cnt_i) && !wr_cnt_i && !sleep_i) |=> flag_i[0]);

    // A flag only rises after a hardware set event (R10).
    assert_no_sw_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_i[0]) || $rose(flag_i[1]) || $rose(flag_i[2]) || $rose(flag_i[3])
        |-> ((flag_i & ~($past(flag_i) | $past(set_evt_i))) == 4'b0));

    // Standby entry empties the status register (R13).
    assert_sleep_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (flag_i == 4'b0 && stat_lo_i == 4'b0));

    // No request leaves on a masked line (R12).
    assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i & ~irq_mask_i) == 4'b0);

endmodule

bind frt_timer frt_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_i    (sleep_entry_i),
    .tick_i     (tick),
    .wr_cnt_i   (wr_cnt),
    .cnt_i      (cnt_q),
    .match_a_i  (match[0]),
    .cclra_i    (stat_lo_q[0]),
    .flag_i     (flag_q),
    .set_evt_i  (set_evt),
    .stat_lo_i  (stat_lo_q),
    .irq_i      (irq_o),
    .irq_mask_i (irq_mask_i)
);

// File: tb/test_frt_timer.sv
// Bench: scoreboard driven. The driver pushes expected items timed from
// the requirements; the monitor pops and compares at the falling edge.
module test_frt_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct {
        int    sel;
        int    exp;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_entry = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        ext_clk = 1'b0;
    logic        cap = 1'b0;
    logic        cmp_a;
    logic        cmp_b;
    logic [3:0]  irq_mask = '0;
    logic [3:0]  irq;

    item_t sb_q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;

    frt_timer i_frt_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep_entry_i (sleep_entry),
        .wr_en_i       (wr_en),
        .wr_addr_i     (wr_addr),
        .wr_data_i     (wr_data),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .ext_clk_i     (ext_clk),
        .cap_i         (cap),
        .cmp_a_o       (cmp_a),
        .cmp_b_o       (cmp_b),
        .irq_mask_i    (irq_mask),
        .irq_o         (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare every queued item at the falling edge.
    always begin
        @(negedge clk);
        while (sb_q.size() > 0) begin
            item_t it;
            int    act;
            it = sb_q.pop_front();
            if (it.sel < 8) rd_addr = it.sel[2:0];
            #1;
            case (it.sel)
                8:       act = int'(irq);
                9:       act = int'(cmp_a);
                10:      act = int'(cmp_b);
                default: act = int'(rd_data);
            endcase
            n_checks++;
            if (act != it.exp) begin
                n_errors++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
    endtask

    task automatic expect_item(input int sel, input int exp, input string tag);
        item_t it;
        it.sel = sel;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Let the monitor drain the queue without crossing a rising edge.
    task automatic settle();
        @(negedge clk);
        #4;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=done", WATCHDOG);
            report();
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);

        // R1 reset state
        expect_item(5, 'h00, "R1 status");
        expect_item(4, 'h00, "R1 control");
        expect_item(1, 'hFFFF, "R1 compare A");
        settle();
        expect_item(2, 'hFFFF, "R1 compare B");
        expect_item(3, 'h0000, "R1 capture");
        expect_item(8, 0, "R1 irq");
        settle();
        expect_item(9, 0, "R1 pin A");
        expect_item(10, 0, "R1 pin B");
        settle();

        // R2 divide by 4
        wr(0, 16'h0000);
        step(7);  expect_item(0, 1, "R2 div4 k=7");  settle();
        step(1);  expect_item(0, 2, "R2 div4 k=8");  settle();
        // R2 divide by 8
        wr(4, 16'h0001);
        wr(0, 16'h0000);
        step(15); expect_item(0, 1, "R2 div8 k=15"); settle();
        step(1);  expect_item(0, 2, "R2 div8 k=16"); settle();
        // R2 divide by 32
        wr(4, 16'h0002);
        wr(0, 16'h0000);
        step(63); expect_item(0, 1, "R2 div32 k=63"); settle();
        step(1);  expect_item(0, 2, "R2 div32 k=64"); settle();

        // R4 register load and read-back
        wr(0, 16'hABCD);
        expect_item(0, 'hABCD, "R4 counter load");
        settle();
        wr(1, 16'h1234);
        expect_item(1, 'h1234, "R4 compare A write");
        settle();

        // R3 external clock
        wr(4, 16'h0003);
        wr(0, 16'h0000);
        ext_clk = 1'b1;
        step(2); expect_item(0, 0, "R3 ext before third edge"); settle();
        step(1); expect_item(0, 1, "R3 ext counted");           settle();
        ext_clk = 1'b0;
        step(6); expect_item(0, 1, "R3 ext falling ignored");   settle();
        ext_clk = 1'b1;
        step(3); expect_item(0, 2, "R3 ext second rise");       settle();
        ext_clk = 1'b0;

        // R5 R6 R7 compare A with clear on match
        irq_mask = 4'b0010;
        wr(1, 16'h0003);
        wr(5, 16'h0005);
        wr(4, 16'h0004);
        wr(0, 16'h0000);
        step(15);
        expect_item(0, 3, "R6 counter before match");
        expect_item(5, 'h05, "R5 no flag before match");
        expect_item(9, 0, "R7 pin A before match");
        settle();
        step(1);
        expect_item(0, 0, "R6 cleared on match A");
        expect_item(5, 'h25, "R5 flag A set");
        expect_item(9, 1, "R7 pin A takes level");
        settle();
        expect_item(8, 'b0010, "R12 irq A");
        settle();

        // R10 clearing semantics
        wr(1, 16'h8000);
        wr(5, 16'h00F4);
        expect_item(5, 'h24, "R10 write one keeps flag");
        settle();
        wr(5, 16'h0004);
        expect_item(5, 'h04, "R10 write zero clears");
        expect_item(8, 0, "R12 irq drops with flag");
        settle();
        wr(5, 16'h00F0);
        expect_item(5, 'h00, "R10 software cannot set");
        settle();

        // R5 R7 compare B free running
        wr(0, 16'h0100);
        wr(2, 16'h0002);
        wr(5, 16'h0008);
        wr(4, 16'h000C);
        wr(0, 16'h0000);
        step(11);
        expect_item(10, 0, "R7 pin B before match");
        expect_item(0, 2, "R5 counter at B value");
        settle();
        step(1);
        expect_item(10, 1, "R7 pin B takes level");
        expect_item(0, 3, "R5 counter runs past match");
        expect_item(5, 'h48, "R5 flag B set");
        settle();
        expect_item(9, 1, "R7 pin A holds");
        settle();
        wr(4, 16'h0004);
        expect_item(10, 0, "R7 pin B disabled");
        settle();
        wr(2, 16'h8000);

        // R8 capture on rising edge
        wr(5, 16'h0002);
        wr(0, 16'h1230);
        step(5);
        cap = 1'b1;
        step(2); expect_item(5, 'h02, "R8 no capture yet"); settle();
        step(1);
        expect_item(3, 'h1231, "R8 captured value");
        expect_item(5, 'h82, "R8 capture flag");
        settle();
        wr(5, 16'h0002);
        cap = 1'b0;
        step(6);
        expect_item(3, 'h1231, "R8 falling ignored value");
        expect_item(5, 'h02, "R8 falling ignored flag");
        settle();
        // R8 capture on falling edge
        wr(5, 16'h0000);
        cap = 1'b1;
        step(5);
        expect_item(5, 'h00, "R8 rising ignored in falling mode");
        settle();
        wr(0, 16'h4000);
        cap = 1'b0;
        step(2); expect_item(5, 'h00, "R8 falling not yet"); settle();
        step(1);
        expect_item(3, 'h4000, "R8 falling captured value");
        expect_item(5, 'h80, "R8 falling flag");
        settle();

        // R9 overflow and R12 masking
        irq_mask = 4'b0001;
        wr(5, 16'h0000);
        wr(0, 16'hFFFE);
        step(7);
        expect_item(0, 'hFFFF, "R9 counter at top");
        expect_item(5, 'h00, "R9 no flag before wrap");
        settle();
        step(1);
        expect_item(0, 'h0000, "R9 counter wrapped");
        expect_item(5, 'h10, "R9 overflow flag");
        expect_item(8, 'b0001, "R12 irq overflow");
        settle();
        irq_mask = 4'b0000;
        #1;
        expect_item(8, 0, "R12 masked irq");
        settle();

        // R11 set wins over clear on the same edge
        wr(5, 16'h0000);
        wr(0, 16'hFFFF);
        step(3);
        wr(5, 16'h0000);
        expect_item(5, 'h10, "R11 set beats clear");
        settle();

        // R13 standby entry
        wr(5, 16'h00FE);
        expect_item(5, 'h1E, "R13 status before standby");
        settle();
        sleep_entry = 1'b1;
        step(1);
        sleep_entry = 1'b0;
        expect_item(5, 'h00, "R13 status after standby");
        settle();

        finished = 1'b1;
        report();
        $finish;
    end

endmodule